// File: doc/BRIEF.md
# Self-Clocked Single-Wire Frame Decoder

The block listens on one serial wire that carries a self-clocked frame and recovers the fields inside it. Every bit has a transition in its middle. The decoder finds the frame by its opening rising edges and locks onto the rising edge in the middle of the second bit. From then on it uses each mid-bit transition as a fresh timing reference. It reads each following bit three quarters of a nominal bit period after that reference.

A frame holds a 2-bit channel code, a 10-bit converter result sent most significant bit first, three status flags and an even parity bit. A frame that checks out is presented as a one-cycle valid strobe together with the decoded fields. A parity mismatch or a frame that overruns its time budget produces a one-cycle error pulse instead, and the previous fields stay on the outputs. The nominal bit period is a parameter counted in system clock cycles. The line input is asynchronous and passes through a synchroniser inside the block.

The result interface is a valid-only stream with no back-pressure. Frames arrive at line rate and cannot be stalled, so the consumer must take the fields in the cycle `o_valid` is high. The fields then stay stable until the next valid strobe.

Top module: `sbd_frame_decoder`

## Requirements
- R1: While reset is applied and after it is released, `o_chan`, `o_result` and `o_flags` are zero, and `o_valid`, `o_parity_err` and `o_timeout` are low.
- R2: Line coding and field order:
  - The line idles low.
  - A bit of value b is driven as b for its first half and as the inverse of b for its second half.
  - A frame is 18 bits: an opening bit of 1, a dummy bit of 0, then CH1, CH0, result bits 9 down to 0, OC, UV, OV and parity.
  - The fields map as `o_chan` = {CH1,CH0}, `o_result[9]` = first result bit, `o_flags[2]` = OC, `o_flags[1]` = UV, `o_flags[0]` = OV.
- R3: The first rising edge seen while idle opens a frame. The bit timing is locked to the next rising edge, which is the middle of the dummy bit. The decoded value therefore does not depend on how long the opening bit's high half lasts.
- R4: Each payload bit is read `3*BIT_CYCLES/4` cycles after the preceding reference transition. The next transition after a read becomes the new reference. Frames whose bit period differs from `BIT_CYCLES` by up to 1/8 decode correctly.
- R5: For a correct frame, `o_valid` is high for exactly one cycle, triggered by the mid-bit transition of the parity bit. In that same cycle `o_chan`, `o_result` and `o_flags` carry the decoded fields.
- R6: Parity is even over CH1 through the parity bit (16 bits). On a mismatch, `o_parity_err` pulses for one cycle, `o_valid` stays low and the output fields keep their previous values.
- R7: If a frame has not completed within `36*BIT_CYCLES` cycles of its opening edge (plus synchroniser delay), `o_timeout` pulses for one cycle. No valid strobe is given and the output fields are held.
- R8: After a timeout or parity error the decoder returns to idle, and the next well-formed frame decodes correctly.
- R9: In any cycle at most one of `o_valid`, `o_parity_err` and `o_timeout` is high, and `o_valid` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| i_line | input | 1 | Asynchronous serial line |
| o_chan | output | 2 | Decoded channel code |
| o_result | output | 10 | Decoded converter result |
| o_flags | output | 3 | Status flags {OC, UV, OV} |
| o_valid | output | 1 | One-cycle strobe for a correct frame |
| o_parity_err | output | 1 | One-cycle pulse on parity mismatch |
| o_timeout | output | 1 | One-cycle pulse when the frame budget expires |

## Verification
The bench sweeps every channel code against every flag pattern and walks a single one through the result field. A design that swapped the field order or read the wrong half of a bit would return wrong values in these sweeps.

Frames with a stretched opening bit catch a decoder that times from the first edge instead of locking on the dummy-bit edge. Frames sent 1/8 fast and 1/8 slow expose a sample point placed at the wrong fraction of the period.

Corrupted parity and truncated or stalled frames must raise exactly one error pulse, give no valid strobe and leave the fields untouched. The timeout pulse is timed against the expected budget. A well-formed frame then follows each error, which catches a decoder that stays stuck after an abort.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  // Bits read after the dummy-bit lock: CH1, CH0, 10 result bits, 3 flags, parity
  localparam int unsigned PAYLOAD_BITS = 16;
  localparam int unsigned FRAME_BITS   = 18;

  typedef enum logic [2:0] {
    ST_IDLE,  // waiting for the opening rising edge
    ST_ARM,   // waiting for the dummy-bit rising edge
    ST_WAIT,  // counting to the three-quarter sample point
    ST_HUNT,  // waiting for the next mid-bit transition
    ST_TAIL   // waiting for the parity bit's mid-bit transition
  } dec_state_e;
endpackage

// File: rtl/sbd_line_sync.sv
module sbd_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i_line,
  output logic o_level,
  output logic o_edge,
  output logic o_rise
);
  logic [STAGES-1:0] chain;
  logic              prev;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= i_line;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[g] <= 1'b0;
        else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev <= 1'b0;
    else        prev <= chain[STAGES-1];

  assign o_level = chain[STAGES-1];
  assign o_edge  = chain[STAGES-1] ^ prev;
  assign o_rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/sbd_cycle_timer.sv
module sbd_cycle_timer #(
  parameter int unsigned LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic i_run,
  output logic o_hit
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign o_hit = i_run && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)              cnt <= '0;
    else if (!i_run || o_hit) cnt <= '0;
    else                     cnt <= cnt + 1'b1;

  AST_TIMER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT)) else $error("timer count beyond limit"); // R4
endmodule

// File: rtl/sbd_frame_decoder.sv
module sbd_frame_decoder
  import sbd_pkg::*;
#(
  parameter int unsigned BIT_CYCLES  = 8333,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       i_line,
  output logic [1:0] o_chan,
  output logic [9:0] o_result,
  output logic [2:0] o_flags,
  output logic       o_valid,
  output logic       o_parity_err,
  output logic       o_timeout
);
  localparam int unsigned SAMPLE_CYC = (3 * BIT_CYCLES) / 4;
  localparam int unsigned WD_LIMIT   = 2 * FRAME_BITS * BIT_CYCLES;
  localparam int unsigned IDX_W      = $clog2(PAYLOAD_BITS + 1);

  dec_state_e              state;
  logic [PAYLOAD_BITS-1:0] shreg;
  logic [IDX_W-1:0]        idx;
  logic                    level, edge_any, rise;
  logic                    ph_hit, wd_expire;

  sbd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .i_line(i_line),
    .o_level(level), .o_edge(edge_any), .o_rise(rise)
  );

  // Three-quarter sample point after each reference transition
  sbd_cycle_timer #(.LIMIT(SAMPLE_CYC)) u_phase (
    .clk(clk), .rst_n(rst_n), .i_run(state == ST_WAIT), .o_hit(ph_hit)
  );

  // Whole-frame budget, running from the opening edge
  sbd_cycle_timer #(.LIMIT(WD_LIMIT)) u_watchdog (
    .clk(clk), .rst_n(rst_n), .i_run(state != ST_IDLE), .o_hit(wd_expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      shreg        <= '0;
      idx          <= '0;
      o_chan       <= '0;
      o_result     <= '0;
      o_flags      <= '0;
      o_valid      <= 1'b0;
      o_parity_err <= 1'b0;
      o_timeout    <= 1'b0;
    end else begin
      o_valid      <= 1'b0;
      o_parity_err <= 1'b0;
      o_timeout    <= 1'b0;
      if (wd_expire) begin
        state     <= ST_IDLE;
        o_timeout <= 1'b1;
      end else begin
        unique case (state)
          ST_IDLE: if (rise) state <= ST_ARM;
          ST_ARM: if (rise) begin
            state <= ST_WAIT;
            idx   <= '0;
          end
          ST_WAIT: if (ph_hit) begin
            shreg <= {shreg[PAYLOAD_BITS-2:0], level};
            idx   <= idx + 1'b1;
            state <= (idx == IDX_W'(PAYLOAD_BITS - 1)) ? ST_TAIL : ST_HUNT;
          end
          ST_HUNT: if (edge_any) state <= ST_WAIT;
          ST_TAIL: if (edge_any) begin
            state <= ST_IDLE;
            if (^shreg == 1'b0) begin
              o_chan   <= shreg[15:14];
              o_result <= shreg[13:4];
              o_flags  <= shreg[3:1];
              o_valid  <= 1'b1;
            end else begin
              o_parity_err <= 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({o_valid, o_parity_err, o_timeout}) <= 1) else $error("two outcomes at once"); // R9
  AST_VALID_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
    o_valid |=> !o_valid) else $error("valid held two cycles"); // R9
  AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({o_chan, o_result, o_flags}) |-> o_valid) else $error("fields moved without valid"); // R6
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (o_timeout || o_parity_err) |-> state == ST_IDLE) else $error("abort did not return to idle"); // R8
endmodule

// File: tb/sbd_frame_decoder_tb.sv
module sbd_frame_decoder_tb;
  localparam int unsigned BITC = 16;
  localparam int unsigned HALF = BITC / 2;
  localparam int unsigned WDL  = 36 * BITC;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line = 1'b0;
  logic [1:0] o_chan;
  logic [9:0] o_result;
  logic [2:0] o_flags;
  logic       o_valid, o_parity_err, o_timeout;

  int n_tests = 0, n_fail = 0;
  int n_valid = 0, n_perr = 0, n_tmo = 0;
  int cyc = 0, tmo_cyc = 0;

  always #4 clk = ~clk;

  sbd_frame_decoder #(.BIT_CYCLES(BITC), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .i_line(line),
    .o_chan(o_chan), .o_result(o_result), .o_flags(o_flags),
    .o_valid(o_valid), .o_parity_err(o_parity_err), .o_timeout(o_timeout)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (rst_n) begin
    if (o_valid)      n_valid = n_valid + 1;
    if (o_parity_err) n_perr  = n_perr + 1;
    if (o_timeout) begin
      n_tmo   = n_tmo + 1;
      tmo_cyc = cyc;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic v, input int n);
    line = v;
    repeat (n) @(negedge clk);
  endtask

  // stretch: extra halves on the opening bit's high half; cut: stop after this many bits
  task automatic send(input logic [1:0] ch, input logic [9:0] adc, input logic [2:0] fl,
                      input bit bad_par, input int half, input int stretch, input int cut);
    logic [17:0] bits;
    bits = {1'b1, 1'b0, ch, adc, fl, (^{ch, adc, fl}) ^ bad_par};
    for (int i = 17; i >= 0; i--) begin
      if (17 - i >= cut) break;
      drive(bits[i], (i == 17) ? half * (1 + stretch) : half);
      drive(~bits[i], half);
    end
    drive(1'b0, 4 * half);
  endtask

  task automatic expect_good(input logic [1:0] ch, input logic [9:0] adc,
                             input logic [2:0] fl, input int half, input int stretch,
                             input string req);
    int v0, p0, t0;
    v0 = n_valid; p0 = n_perr; t0 = n_tmo;
    send(ch, adc, fl, 1'b0, half, stretch, 18);
    check(n_valid == v0 + 1, req, "valid pulse count", n_valid - v0, 1);
    check(n_perr == p0 && n_tmo == t0, req, "no error pulse", n_perr + n_tmo - p0 - t0, 0);
    check(o_chan == ch, req, "channel", o_chan, ch);
    check(o_result == adc, req, "result", o_result, adc);
    check(o_flags == fl, req, "flags", o_flags, fl);
  endtask

  task automatic expect_fields(input logic [1:0] ch, input logic [9:0] adc,
                               input logic [2:0] fl, input string req);
    check({o_chan, o_result, o_flags} == {ch, adc, fl}, req, "fields held",
          {o_chan, o_result, o_flags}, {ch, adc, fl});
  endtask

  initial begin : main
    int v0, p0, t0, start;
    logic [9:0] adc;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(o_chan == 0 && o_result == 0 && o_flags == 0, "R1", "fields in reset",
          {o_chan, o_result, o_flags}, 0);
    check(!o_valid && !o_parity_err && !o_timeout, "R1", "pulses in reset",
          {o_valid, o_parity_err, o_timeout}, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(o_chan == 0 && o_result == 0 && o_flags == 0 && n_valid == 0, "R1",
          "fields after reset", {o_chan, o_result, o_flags}, 0);

    // R2 R5: every channel against every flag pattern
    for (int ch = 0; ch < 4; ch++)
      for (int fl = 0; fl < 8; fl++) begin
        adc = 10'((ch * 293 + fl * 71 + 5) & 10'h3FF);
        expect_good(2'(ch), adc, 3'(fl), HALF, 0, "R2");
      end
    // R2: walking one through the result, then all ones / all zeros
    for (int b = 0; b < 10; b++) expect_good(2'b01, 10'(1 << b), 3'b101, HALF, 0, "R2");
    expect_good(2'b11, 10'h3FF, 3'b111, HALF, 0, "R5");
    expect_good(2'b00, 10'h000, 3'b000, HALF, 0, "R5");

    // R3: long opening bit, timing must come from the dummy-bit edge
    expect_good(2'b10, 10'h2A5, 3'b011, HALF, 3, "R3");
    expect_good(2'b01, 10'h15A, 3'b100, HALF, 1, "R3");

    // R4: period 1/8 short and 1/8 long
    expect_good(2'b10, 10'h19C, 3'b110, HALF - 1, 0, "R4");
    expect_good(2'b01, 10'h263, 3'b001, HALF + 1, 0, "R4");

    // R6: parity corrupted
    for (int k = 0; k < 3; k++) begin
      v0 = n_valid; p0 = n_perr;
      send(2'(k), 10'(k * 111 + 7), 3'(k + 2), 1'b1, HALF, 0, 18);
      check(n_perr == p0 + 1, "R6", "parity error pulse", n_perr - p0, 1);
      check(n_valid == v0, "R6", "no valid on bad parity", n_valid - v0, 0);
      expect_fields(2'b01, 10'h263, 3'b001, "R6");
    end
    // R8: recovery after parity error
    expect_good(2'b11, 10'h0F0, 3'b010, HALF, 0, "R8");

    // R7: frame truncated after five bits
    v0 = n_valid; t0 = n_tmo;
    @(negedge clk);
    start = cyc;
    send(2'b10, 10'h111, 3'b111, 1'b0, HALF, 0, 5);
    repeat (WDL) @(negedge clk);
    check(n_tmo == t0 + 1, "R7", "timeout pulse", n_tmo - t0, 1);
    check(tmo_cyc - start >= WDL && tmo_cyc - start <= WDL + 4, "R7", "timeout delay",
          tmo_cyc - start, WDL + 3);
    check(n_valid == v0, "R7", "no valid on timeout", n_valid - v0, 0);
    expect_fields(2'b11, 10'h0F0, 3'b010, "R7");
    expect_good(2'b00, 10'h3C3, 3'b101, HALF, 0, "R8");

    // R7: opening edge with no dummy-bit edge (line stuck high)
    t0 = n_tmo; v0 = n_valid;
    drive(1'b1, WDL + 20);
    drive(1'b0, 4 * HALF);
    check(n_tmo == t0 + 1, "R7", "timeout while armed", n_tmo - t0, 1);
    check(n_valid == v0, "R7", "no valid while armed", n_valid - v0, 0);
    expect_fields(2'b00, 10'h3C3, 3'b101, "R7");
    expect_good(2'b10, 10'h0AA, 3'b110, HALF, 0, "R8");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got %0d cycles expected completion", 200000);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule